// File: doc/BRIEF.md
# Interlocked Handshake Parallel Port

This block is a byte-wide parallel port that moves data between a simple processor register bus and an external device. It uses two handshake wires whose roles are fixed by the transfer direction. When the port receives data, the device drives an active-low "data available" strobe into the block and the block answers on a ready line. When the port sends data, the block drives the strobe and the device answers on the ready line. The block has one handshake input pin, `hs_in`, and one handshake output pin, `hs_out`; the direction setting decides what each of them means.

In receive mode the first falling strobe captures the data pins into a holding register. The block then pulls ready low and pulses an interrupt request. Later strobe pulses cannot touch the holding register until the processor reads it. Ready goes high again only after the read has happened and the strobe is high. In send mode a processor write places the byte on the pins, and one cycle later the strobe goes low. The strobe is released, with an interrupt pulse, when the device pulls its ready line low. A later transfer waits until ready is high again.

The handshake input passes through a synchronizer, so edges are seen a fixed number of cycles late. The data pins are assumed stable while the strobe is low. Before handshake mode is switched on, software presets the output-line bit to 1. Once the mode is on, bus writes to that bit are ignored.

Top module: `hsport`

## Requirements
- R1: After reset, `hs_out` is 1, `irq` is 0, `pad_oe` is 0, and the configuration register (address 2) reads 0, meaning handshake off and receive mode.
- R2: The configuration register at address 2 has bit 0 = handshake enable and bit 1 = direction (1 = send). In enabled receive mode, a fall of `hs_in` captures `pad_din`. Exactly 3 clock edges after `hs_in` falls, `hs_out` (ready) is 0 and `irq` is 1.
- R3: In receive mode, once a byte is captured, further strobe pulses neither change the byte read at address 0 nor raise `irq`, until address 0 has been read.
- R4: In receive mode, ready (`hs_out`) returns to 1 only after address 0 has been read and `hs_in` is high. A read while the strobe is low, or a high strobe without a read, keeps it at 0.
- R5: In enabled send mode, `pad_oe` is 1. A write to address 0 puts the byte on `pad_dout` one edge later while `hs_out` is still 1. `hs_out` (strobe) goes to 0 on the following edge.
- R6: In send mode, while the strobe is low, a fall of `hs_in` (device ready) releases the strobe to 1 and pulses `irq`, 3 clock edges after `hs_in` falls.
- R7: In send mode, a write during a handshake overwrites `pad_dout` at once. The new transfer's strobe is not asserted until `hs_in` has returned high.
- R8: Reading address 1 returns bit 1 = current `hs_out` and bit 0 = synchronized `hs_in`, with all other bits 0.
- R9: Bit 1 of a write to address 1 sets the output-line preset only while handshake is disabled. In that state `hs_out` follows the preset, which resets to 1. While handshake is enabled, such writes are ignored.
- R10: Every `irq` assertion lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 0 acknowledges received data) |
| bus_addr | input | 2 | Register address: 0 data, 1 handshake lines, 2 configuration |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pad_din | input | 8 | External data pins, input side |
| pad_dout | output | 8 | External data pins, output side |
| pad_oe | output | 1 | Output enable for the data pins (send mode) |
| hs_in | input | 1 | Handshake input: strobe in receive mode, device ready in send mode |
| hs_out | output | 1 | Handshake output: ready in receive mode, strobe in send mode |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
Receive transfers are driven with random bytes and a random number of extra strobe pulses, and the pin data is changed after each capture. A byte taken from a later pulse is thereby told apart from the one the first pulse captured. Read-before-release and release-before-read orderings are both tried, which separates a ready that waits for both conditions from one that waits for only one. Send transfers are run with random device response delays, and also with a write placed in the middle of a strobe. That case checks that data can be overwritten mid-handshake and that the follow-up strobe waits for ready to return.

// File: rtl/hsport_pkg.sv
// Shared types for the handshake port: state encodings of both controllers.
package hsport_pkg;
    typedef enum logic [0:0] {IN_IDLE = 1'b0, IN_FULL = 1'b1} in_state_t;
    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_SETUP = 2'd1,
        OUT_STRB  = 2'd2,
        OUT_WAIT  = 2'd3
    } out_state_t;
endpackage

// File: rtl/hsport_sync.sv
// Multi-stage synchronizer for one asynchronous handshake input.
// Assumes the input is a level that may change at any time; the output
// lags it by STAGES clock edges. Resets to 1 (the idle level of both lines).
module hsport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= async_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], async_i};
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hsport_in_ctl.sv
// Receive-side controller. On the first falling synchronized strobe it
// captures the data pins, drops ready and pulses the interrupt. The
// captured byte is held against further strobes until a bus read; ready
// returns once that read has been seen and the strobe is high.
// Assumes pad data is stable while the strobe is low. Held idle when
// not enabled.
module hsport_in_ctl
    import hsport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         strb_s_i,
    input  logic [W-1:0] din_i,
    input  logic         rd_i,
    output logic [W-1:0] lat_o,
    output logic         rdy_o,
    output logic         irq_o
);
    in_state_t   st_q;
    logic        prev_q;
    logic        rd_seen_q;
    logic [W-1:0] lat_q;
    logic        fall;

    assign fall = prev_q & ~strb_s_i;

    // Capture, protection and ready-release sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= IN_IDLE;
            prev_q    <= 1'b1;
            rd_seen_q <= 1'b0;
            lat_q     <= '0;
            irq_o     <= 1'b0;
        end else begin
            prev_q <= strb_s_i;
            irq_o  <= 1'b0;
            if (!en_i) begin
                st_q      <= IN_IDLE;
                rd_seen_q <= 1'b0;
            end else begin
                case (st_q)
                    IN_IDLE: begin
                        if (fall) begin
                            lat_q     <= din_i;
                            st_q      <= IN_FULL;
                            rd_seen_q <= 1'b0;
                            irq_o     <= 1'b1;
                        end
                    end
                    default: begin
                        if (rd_i) rd_seen_q <= 1'b1;
                        if (rd_seen_q && strb_s_i) st_q <= IN_IDLE;
                    end
                endcase
            end
        end
    end

    assign lat_o = lat_q;
    assign rdy_o = (st_q == IN_IDLE);

    // R3
    latch_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == IN_FULL) |=> $stable(lat_q));
    // R4
    rdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rdy_o) && $past(en_i)) |-> ($past(rd_seen_q) && $past(strb_s_i)));
    // R10
    in_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
endmodule

// File: rtl/hsport_out_ctl.sv
// Send-side controller. A bus write updates the output byte unconditionally
// (no protection); if ready is high the strobe is lowered one cycle after
// the data, otherwise the transfer is held pending. The strobe is released
// with an interrupt pulse when ready falls, and the next transfer waits for
// ready to return high. Held idle when not enabled.
module hsport_out_ctl
    import hsport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         rdy_s_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] dout_o,
    output logic         strb_o,
    output logic         irq_o
);
    out_state_t   st_q;
    logic         pend_q;
    logic [W-1:0] out_q;

    // Output data register, strobe sequencing and pending transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= OUT_IDLE;
            pend_q <= 1'b0;
            out_q  <= '0;
            irq_o  <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            if (wr_i) out_q <= wdata_i;
            if (!en_i) begin
                st_q   <= OUT_IDLE;
                pend_q <= 1'b0;
            end else begin
                case (st_q)
                    OUT_IDLE: begin
                        if ((wr_i || pend_q) && rdy_s_i) begin
                            st_q   <= OUT_SETUP;
                            pend_q <= 1'b0;
                        end else if (wr_i) begin
                            pend_q <= 1'b1;
                        end
                    end
                    OUT_SETUP: begin
                        if (wr_i) pend_q <= 1'b1;
                        st_q <= OUT_STRB;
                    end
                    OUT_STRB: begin
                        if (wr_i) pend_q <= 1'b1;
                        if (!rdy_s_i) begin
                            st_q  <= OUT_WAIT;
                            irq_o <= 1'b1;
                        end
                    end
                    default: begin
                        if (wr_i) pend_q <= 1'b1;
                        if (rdy_s_i) st_q <= OUT_IDLE;
                    end
                endcase
            end
        end
    end

    assign dout_o = out_q;
    assign strb_o = (st_q != OUT_STRB);

    // R6
    strb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strb_o) && $past(en_i)) |-> !$past(rdy_s_i));
    // R7
    strb_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_o) |-> $past(rdy_s_i, 2));
    // R10
    out_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
endmodule

// File: rtl/hsport.sv
// Top of the interlocked handshake port: register decode, configuration,
// output-line preset, and the routing of the shared handshake pins to the
// receive or send controller according to the direction bit.
// Assumes bus strobes are single-cycle and that configuration is not
// changed while a transfer is in progress.
module hsport #(
    parameter int W       = 8,
    parameter int STAGES  = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pad_din,
    output logic [W-1:0] pad_dout,
    output logic         pad_oe,
    input  logic         hs_in,
    output logic         hs_out,
    output logic         irq
);
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_LINE = 2'd1;
    localparam logic [1:0] A_CFG  = 2'd2;

    logic         en_q, dir_q, preset_q;
    logic         hs_s;
    logic         in_rdy, in_irq, out_strb, out_irq;
    logic [W-1:0] in_lat, out_data;
    logic         rx_en, tx_en;

    assign rx_en = en_q & ~dir_q;
    assign tx_en = en_q & dir_q;

    // Configuration register and output-line preset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            dir_q    <= 1'b0;
            preset_q <= 1'b1;
        end else if (bus_wr) begin
            if (bus_addr == A_CFG) begin
                en_q  <= bus_wdata[0];
                dir_q <= bus_wdata[1];
            end
            if (bus_addr == A_LINE && !en_q) preset_q <= bus_wdata[1];
        end
    end

    hsport_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(hs_in), .sync_o(hs_s)
    );

    hsport_in_ctl #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en_i(rx_en), .strb_s_i(hs_s),
        .din_i(pad_din), .rd_i(bus_rd && bus_addr == A_DATA),
        .lat_o(in_lat), .rdy_o(in_rdy), .irq_o(in_irq)
    );

    hsport_out_ctl #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en_i(tx_en), .rdy_s_i(hs_s),
        .wr_i(bus_wr && bus_addr == A_DATA), .wdata_i(bus_wdata),
        .dout_o(out_data), .strb_o(out_strb), .irq_o(out_irq)
    );

    // Handshake output: preset when disabled, controller line otherwise.
    always_comb begin
        if (!en_q)      hs_out = preset_q;
        else if (dir_q) hs_out = out_strb;
        else            hs_out = in_rdy;
    end

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA:  bus_rdata = dir_q ? out_data : (en_q ? in_lat : pad_din);
            A_LINE:  bus_rdata = {{(W-2){1'b0}}, hs_out, hs_s};
            A_CFG:   bus_rdata = {{(W-2){1'b0}}, dir_q, en_q};
            default: bus_rdata = '0;
        endcase
    end

    assign irq      = (rx_en & in_irq) | (tx_en & out_irq);
    assign pad_dout = out_data;
    assign pad_oe   = dir_q;

    // R9
    preset_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && bus_wr && bus_addr == A_LINE) |=> $stable(preset_q));
endmodule

// File: tb/hsport_bench.sv
module hsport_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_din = 8'd0;
    logic [7:0] pad_dout;
    logic       pad_oe, hs_in = 1'b1, hs_out, irq;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    logic irq_prev = 1'b0;
    int long_irq = 0;

    always #2 clk = ~clk;

    hsport u_hsport (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_din(pad_din), .pad_dout(pad_dout), .pad_oe(pad_oe),
        .hs_in(hs_in), .hs_out(hs_out), .irq(irq)
    );

    // Count interrupt pulses and catch any lasting two cycles.
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irq_cnt++;
            if (irq && irq_prev) long_irq++;
            irq_prev = irq;
        end
    end

    function automatic logic [7:0] exp_line(logic o, logic i);
        return {6'b0, o, i};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // One receive transfer with extra pulses; rd_first reads before release.
    task automatic rx_xfer(logic [7:0] d, int extra, logic rd_first);
        logic [7:0] r;
        int c0;
        pad_din = d;
        c0 = irq_cnt;
        @(negedge clk); hs_in = 1'b0;
        cyc(3);
        check("R2 irq at 3 edges", irq, 1'b1);
        check("R2 ready low", hs_out, 1'b0);
        pad_din = ~d;
        if (rd_first) begin
            bus_read(2'd0, r);
            check("R3 latched byte", r, d);
            cyc(5);
            check("R4 read but strobe low", hs_out, 1'b0);
            hs_in = 1'b1;
            cyc(5);
            check("R4 release after read+high", hs_out, 1'b1);
        end else begin
            hs_in = 1'b1;
            cyc(4);
            for (int k = 0; k < extra; k++) begin
                pad_din = 8'($urandom);
                hs_in = 1'b0; cyc(4);
                hs_in = 1'b1; cyc(4);
            end
            check("R4 high strobe no read", hs_out, 1'b0);
            bus_read(2'd0, r);
            check("R3 latched byte", r, d);
            cyc(4);
            check("R4 release after read", hs_out, 1'b1);
        end
        check("R3 one irq per transfer", irq_cnt - c0, 1);
    endtask

    // One send transfer with a device responding after random delays.
    task automatic tx_xfer(logic [7:0] d);
        int c0, n;
        c0 = irq_cnt;
        bus_write(2'd0, d);
        check("R5 data before strobe", {pad_dout, hs_out}, {d, 1'b1});
        cyc(1);
        check("R5 strobe low", hs_out, 1'b0);
        cyc(1 + ($urandom % 4));
        hs_in = 1'b0;
        n = 0;
        while (hs_out == 1'b0 && n < 20) begin cyc(1); n++; end
        check("R6 release latency", n, 3);
        cyc(1 + ($urandom % 4));
        hs_in = 1'b1;
        cyc(4);
        check("R6 one irq", irq_cnt - c0, 1);
    endtask

    initial begin
        logic [7:0] r;
        void'($urandom(32'd4242));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R1 hs_out", hs_out, 1'b1);
        check("R1 irq", irq, 1'b0);
        check("R1 pad_oe", pad_oe, 1'b0);
        bus_read(2'd2, r);
        check("R1 config", r, 8'h00);

        // R9 preset while disabled
        bus_write(2'd1, 8'h00);
        check("R9 preset 0", hs_out, 1'b0);
        bus_write(2'd1, 8'h02);
        check("R9 preset 1", hs_out, 1'b1);

        // receive mode
        bus_write(2'd2, 8'h01);
        bus_write(2'd1, 8'h00);
        cyc(1);
        check("R9 ignored while enabled", hs_out, 1'b1);
        bus_read(2'd1, r);
        check("R8 idle lines", r, exp_line(1'b1, 1'b1));
        rx_xfer(8'h5A, 3, 1'b0);
        rx_xfer(8'hC3, 0, 1'b1);
        pad_din = 8'h77;
        @(negedge clk); hs_in = 1'b0; cyc(4);
        bus_read(2'd1, r);
        check("R8 lines during rx", r, exp_line(1'b0, 1'b0));
        hs_in = 1'b1; cyc(3);
        bus_read(2'd0, r);
        check("R3 byte", r, 8'h77);
        cyc(4);
        for (int i = 0; i < 25; i++)
            rx_xfer(8'($urandom), $urandom % 3, 1'($urandom));

        // send mode
        bus_write(2'd2, 8'h03);
        cyc(1);
        check("R5 pad_oe", pad_oe, 1'b1);
        tx_xfer(8'hA5);
        // R7 overwrite mid-handshake and deferred next transfer
        bus_write(2'd0, 8'h11);
        cyc(1);
        check("R5 strobe low", hs_out, 1'b0);
        bus_write(2'd0, 8'h22);
        check("R7 overwritten data", pad_dout, 8'h22);
        hs_in = 1'b0;
        cyc(4);
        check("R6 released", hs_out, 1'b1);
        cyc(6);
        check("R7 waits for ready", hs_out, 1'b1);
        bus_read(2'd1, r);
        check("R8 lines during tx", r, exp_line(1'b1, 1'b0));
        hs_in = 1'b1;
        cyc(7);
        check("R7 next strobe", hs_out, 1'b0);
        check("R7 data kept", pad_dout, 8'h22);
        hs_in = 1'b0; cyc(5);
        hs_in = 1'b1; cyc(5);
        for (int i = 0; i < 20; i++) tx_xfer(8'($urandom));

        check("R10 single-cycle irq", long_irq, 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule